// File: doc/BRIEF.md
# MDIO Management Target

This block is the device-side end of a two-wire management bus. It watches the bus clock line and the shared data line, both brought into the faster system clock through a synchroniser. It recognises a frame only after a long run of ones followed by a start code, and it decodes both the legacy and the extended frame formats in one decoder. When the frame's port field equals the configured port number, it serves the frame against a small array of 16-bit registers. The shared line is never driven directly: the block presents a data output and a separate output enable, and an external pad and pull-up complete the line.

Legacy frames name the register directly in their second 5-bit field. Extended frames ignore that field and use an internal 16-bit address register instead. That register is loaded by an address frame, used by write and read frames, and advanced by the read-and-increment frame. Read data is launched bit by bit on rising bus-clock edges, so a controller that samples on falling edges sees each bit settled. The driver is released on the first falling edge after the last data bit.

The decoder's states are HUNT, START2, OP, PORT, DEV, TA1, TA2 and DATA. Every transition happens on a sampled rising bus-clock edge. HUNT goes to START2 on a 0 bit once at least 32 ones have been counted, and any 0 bit clears that count. START2 goes to OP after one bit, and the sampled bit selects the format. OP goes to PORT after two bits, PORT goes to DEV after five bits, and DEV goes to TA1 after five bits. At that last DEV bit the frame kind is fixed and any read data is latched. TA1 goes to TA2 after one bit and TA2 goes to DATA after one bit. DATA returns to HUNT after sixteen bits, and there a write or address load is committed.

Top module: `mdio_target`

## Requirements
- R1: After reset, and whenever no read reply is being driven, `bus_dat_oe` and `bus_dat_o` are both 0.
- R2: A frame is accepted only after at least 32 consecutive sampled one bits followed by a 0. A run of 31 ones followed by a 0 returns the decoder to hunting, and the rest of that frame writes nothing and drives nothing. Any longer run of ones is accepted.
- R3: Legacy write works as follows. The start bits are 0 then 1 and the operation bits are 0 then 1, sent first bit first. The 16 data bits, most significant first, are stored in the register whose index is the 5-bit second field. The output enable stays 0 for the whole frame.
- R4: Legacy read uses operation bits 1 then 0. During the first turnaround bit the line stays released. During the second turnaround bit the block drives 0. It then drives the 16 register bits, most significant first, each launched on a rising bus-clock edge. The driver is released after the falling edge that follows the last bit.
- R5: A frame whose 5-bit port field differs from `own_port` drives nothing and changes no register and no address register, in either format.
- R6: Extended frames use start bits 0 then 0. Operation 00 loads the 16-bit payload into the address register. Operation 01 writes the payload to the register that the address register selects.
- R7: An extended frame with operation 11 reads the addressed register and leaves the address unchanged. Operation 10 reads the addressed register and then adds one to the address register.
- R8: Register indices at or above NUM_REGS (default 16) drop writes and read as 0. They do not alias onto lower registers.
- R9: Legacy frames with operation 00 or 11 drive nothing and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Management bus clock from the controller, asynchronous |
| bus_dat_i | input | 1 | Shared management data line as seen at the pad |
| own_port | input | 5 | Port number this target answers to |
| bus_dat_oe | output | 1 | Drive enable for the shared data line |
| bus_dat_o | output | 1 | Value driven while the enable is high |

## Verification
A wrong internal state shows at the ports within one bit time. Suppose the field counter or the state slips by even one bit. The driver then turns on one bit early or late around the turnaround, or the read data comes back shifted, and the per-bit comparison against the model catches it in that same frame. A wrongly latched frame kind, port match or address register stays silent until a later read. For that reason every write, address load and ignored frame is followed by a read frame that exposes the stored value at the data pin.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    localparam int unsigned PRE_LEN = 32;
    localparam int unsigned OP_W    = 2;
    localparam int unsigned FIELD_W = 5;
    localparam int unsigned WORD_W  = 16;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START2,
        ST_OP,
        ST_PORT,
        ST_DEV,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } mdt_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_RD,
        K_RDINC,
        K_WR,
        K_ADDR
    } mdt_kind_e;

endpackage

// File: rtl/mdt_sync.sv
module mdt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_dat,
    output logic clk_rise,
    output logic clk_fall,
    output logic dat_s
);

    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            dat_pipe <= '1;
            clk_last <= 1'b0;
        end else begin
            clk_pipe[0] <= line_clk;
            dat_pipe[0] <= line_dat;
            for (int i = 1; i < STAGES; i++) begin
                clk_pipe[i] <= clk_pipe[i-1];
                dat_pipe[i] <= dat_pipe[i-1];
            end
            clk_last <= clk_pipe[STAGES-1];
        end
    end

    assign clk_rise = clk_pipe[STAGES-1] & ~clk_last;
    assign clk_fall = ~clk_pipe[STAGES-1] & clk_last;
    assign dat_s    = dat_pipe[STAGES-1];

endmodule

// File: rtl/mdt_regs.sv
module mdt_regs #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned AW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
    logic [NUM_REGS-1:0]             wsel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wsel[g] = we && (waddr == AW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wsel[i]) mem_q[i] <= wdata;
            end
        end
    end

    assign rdata = (raddr < AW'(NUM_REGS)) ? mem_q[raddr[IW-1:0]] : '0;

    assert_oob_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr >= AW'(NUM_REGS))) |=> $stable(mem_q));

endmodule

// File: rtl/mdt_frame.sv
module mdt_frame
    import mdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               dat_i,
    input  logic [FIELD_W-1:0] own_port_i,
    input  logic [WORD_W-1:0]  rdata_i,
    output logic [WORD_W-1:0]  raddr_o,
    output logic               we_o,
    output logic [WORD_W-1:0]  waddr_o,
    output logic [WORD_W-1:0]  wdata_o,
    output logic               oe_o,
    output logic               do_o
);

    localparam int unsigned ONES_W = $clog2(PRE_LEN + 1);
    localparam int unsigned CNT_W  = $clog2(WORD_W);
    localparam int unsigned PAD_W  = WORD_W - FIELD_W;

    mdt_state_e         state_q, state_d;
    mdt_kind_e          kind_q, kind_d;
    logic [ONES_W-1:0]  ones_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               ext_q;
    logic [OP_W-1:0]    op_q;
    logic [FIELD_W-1:0] port_q;
    logic [FIELD_W-1:0] dev_q;
    logic [WORD_W-1:0]  shreg_q;
    logic [WORD_W-1:0]  addr_q;

    logic op_end, fld_end, data_end, is_rd;

    assign op_end   = (cnt_q == CNT_W'(OP_W - 1));
    assign fld_end  = (cnt_q == CNT_W'(FIELD_W - 1));
    assign data_end = (cnt_q == CNT_W'(WORD_W - 1));
    assign is_rd    = (kind_q == K_RD) || (kind_q == K_RDINC);

    // frame kind decided at the last bit of the second field
    always_comb begin
        kind_d = K_NONE;
        if (port_q == own_port_i) begin
            if (ext_q) begin
                unique case (op_q)
                    2'b00:   kind_d = K_ADDR;
                    2'b01:   kind_d = K_WR;
                    2'b10:   kind_d = K_RDINC;
                    default: kind_d = K_RD;
                endcase
            end else if (op_q == 2'b01) begin
                kind_d = K_WR;
            end else if (op_q == 2'b10) begin
                kind_d = K_RD;
            end
        end
    end

    assign raddr_o = ext_q ? addr_q : {{PAD_W{1'b0}}, dev_q[FIELD_W-2:0], dat_i};
    assign waddr_o = ext_q ? addr_q : {{PAD_W{1'b0}}, dev_q};
    assign wdata_o = {shreg_q[WORD_W-2:0], dat_i};
    assign we_o    = rise_i && (state_q == ST_DATA) && data_end && (kind_q == K_WR);

    // next state
    always_comb begin
        state_d = state_q;
        if (rise_i) begin
            unique case (state_q)
                ST_HUNT:   if (!dat_i && ones_q == ONES_W'(PRE_LEN)) state_d = ST_START2;
                ST_START2: state_d = ST_OP;
                ST_OP:     if (op_end) state_d = ST_PORT;
                ST_PORT:   if (fld_end) state_d = ST_DEV;
                ST_DEV:    if (fld_end) state_d = ST_TA1;
                ST_TA1:    state_d = ST_TA2;
                ST_TA2:    state_d = ST_DATA;
                ST_DATA:   if (data_end) state_d = ST_HUNT;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // field capture and commits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            ones_q  <= '0;
            cnt_q   <= '0;
            ext_q   <= 1'b0;
            op_q    <= '0;
            port_q  <= '0;
            dev_q   <= '0;
            shreg_q <= '0;
            addr_q  <= '0;
        end else if (rise_i) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (!dat_i)                         ones_q <= '0;
                    else if (ones_q != ONES_W'(PRE_LEN)) ones_q <= ones_q + 1'b1;
                end
                ST_START2: begin
                    ext_q  <= ~dat_i;
                    cnt_q  <= '0;
                    kind_q <= K_NONE;
                end
                ST_OP: begin
                    op_q  <= {op_q[OP_W-2:0], dat_i};
                    cnt_q <= op_end ? '0 : cnt_q + 1'b1;
                end
                ST_PORT: begin
                    port_q <= {port_q[FIELD_W-2:0], dat_i};
                    cnt_q  <= fld_end ? '0 : cnt_q + 1'b1;
                end
                ST_DEV: begin
                    dev_q <= {dev_q[FIELD_W-2:0], dat_i};
                    cnt_q <= fld_end ? '0 : cnt_q + 1'b1;
                    if (fld_end) begin
                        kind_q  <= kind_d;
                        shreg_q <= rdata_i;
                    end
                end
                ST_DATA: begin
                    shreg_q <= wdata_o;
                    cnt_q   <= data_end ? '0 : cnt_q + 1'b1;
                    if (data_end && kind_q == K_ADDR)  addr_q <= wdata_o;
                    if (data_end && kind_q == K_RDINC) addr_q <= addr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // line driver: launched on rising edges, released on a falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_o <= 1'b0;
            do_o <= 1'b0;
        end else if (rise_i) begin
            unique case (state_q)
                ST_TA2: begin
                    oe_o <= is_rd;
                    do_o <= 1'b0;
                end
                ST_DATA: begin
                    oe_o <= is_rd;
                    do_o <= is_rd & shreg_q[WORD_W-1];
                end
                default: begin
                    oe_o <= 1'b0;
                    do_o <= 1'b0;
                end
            endcase
        end else if (fall_i && state_q != ST_TA2 && state_q != ST_DATA) begin
            oe_o <= 1'b0;
            do_o <= 1'b0;
        end
    end

    assert_ones_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= ONES_W'(PRE_LEN));

    assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && (kind_q == K_WR || kind_q == K_ADDR)) |-> !oe_o);

    assert_launch_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(rise_i));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !do_o);

    assert_ignored_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_NONE && (state_q == ST_TA2 || state_q == ST_DATA)) |-> !oe_o);

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && state_q == ST_DATA && data_end && kind_q == K_RDINC)
        |=> addr_q == $past(addr_q) + 1'b1);

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdt_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_clk_i,
    input  logic               bus_dat_i,
    input  logic [FIELD_W-1:0] own_port,
    output logic               bus_dat_oe,
    output logic               bus_dat_o
);

    logic              rise, fall, dat;
    logic              we;
    logic [WORD_W-1:0] waddr, wdata, raddr, rdata;

    mdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (bus_clk_i),
        .line_dat (bus_dat_i),
        .clk_rise (rise),
        .clk_fall (fall),
        .dat_s    (dat)
    );

    mdt_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fall_i     (fall),
        .dat_i      (dat),
        .own_port_i (own_port),
        .rdata_i    (rdata),
        .raddr_o    (raddr),
        .we_o       (we),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .oe_o       (bus_dat_oe),
        .do_o       (bus_dat_o)
    );

    mdt_regs #(.NUM_REGS(NUM_REGS), .DATA_W(WORD_W), .AW(WORD_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

endmodule

// File: tb/sim_mdio_target.sv
`timescale 1ns/1ps
module sim_mdio_target;

    localparam int NREG = 16;
    localparam logic [4:0] OWN = 5'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0;
    logic line_dat = 1'b1;
    logic oe, dout;

    always #5 clk = ~clk;

    mdio_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_clk_i  (line_clk),
        .bus_dat_i  (line_dat),
        .own_port   (OWN),
        .bus_dat_oe (oe),
        .bus_dat_o  (dout)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] mdl [NREG];
    logic [15:0] mdl_addr;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_pins(input bit e_oe, input bit e_do, input string tag);
        n_checks++;
        if (oe !== e_oe || dout !== e_do) begin
            n_fail++;
            $display("FAIL %s: actual oe=%0b do=%0b expected oe=%0b do=%0b at %0t",
                     tag, oe, dout, e_oe, e_do, $time);
        end
    endtask

    // one bit time: low phase with the line set, then high phase, check before falling
    task automatic send_bit(input bit v, input bit e_oe, input bit e_do, input string tag);
        line_dat = v;
        tick(8);
        line_clk = 1'b1;
        tick(7);
        check_pins(e_oe, e_do, tag);
        tick(1);
        line_clk = 1'b0;
    endtask

    task automatic frame(input int pre, input bit ext, input bit [1:0] op,
                         input bit [4:0] port, input bit [4:0] dev,
                         input bit [15:0] wd, input string tag);
        int kind;  // 0 none, 1 read, 2 read+inc, 3 write, 4 address
        int idx;
        bit rd;
        bit [15:0] rv;
        kind = 0;
        if (pre >= 32 && port == OWN) begin
            if (ext) kind = (op == 2'b00) ? 4 : (op == 2'b01) ? 3 : (op == 2'b10) ? 2 : 1;
            else     kind = (op == 2'b01) ? 3 : (op == 2'b10) ? 1 : 0;
        end
        idx = ext ? int'(mdl_addr) : int'(dev);
        rv  = (idx < NREG) ? mdl[idx] : 16'h0;
        rd  = (kind == 1 || kind == 2);
        for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b0, 1'b0, tag);
        send_bit(1'b0, 1'b0, 1'b0, tag);
        send_bit(ext ? 1'b0 : 1'b1, 1'b0, 1'b0, tag);
        for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b0, 1'b0, tag);
        for (int i = 4; i >= 0; i--) send_bit(port[i], 1'b0, 1'b0, tag);
        for (int i = 4; i >= 0; i--) send_bit(dev[i], 1'b0, 1'b0, tag);
        send_bit(1'b1, 1'b0, 1'b0, tag);
        send_bit(op[1] ? 1'b1 : 1'b0, rd, 1'b0, tag);
        for (int i = 15; i >= 0; i--)
            send_bit(op[1] ? 1'b1 : wd[i], rd, rd ? rv[i] : 1'b0, tag);
        tick(6);
        check_pins(1'b0, 1'b0, "R4 release");
        case (kind)
            3: if (idx < NREG) mdl[idx] = wd;
            4: mdl_addr = wd;
            2: mdl_addr = mdl_addr + 16'd1;
            default: ;
        endcase
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 16'h0;
        mdl_addr = 16'h0;
        tick(4);
        check_pins(1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        tick(4);
        check_pins(1'b0, 1'b0, "R1 idle");

        frame(32, 0, 2'b01, OWN,   5'd2,  16'hA5C3, "R3 legacy write");
        frame(32, 0, 2'b10, OWN,   5'd2,  16'h0,    "R4 legacy read");
        frame(32, 0, 2'b01, 5'd7,  5'd2,  16'hFFFF, "R5 foreign write");
        frame(32, 0, 2'b10, 5'd7,  5'd2,  16'h0,    "R5 foreign read");
        frame(32, 0, 2'b10, OWN,   5'd2,  16'h0,    "R5 readback");
        frame(31, 0, 2'b01, OWN,   5'd4,  16'h1234, "R2 short preamble");
        frame(32, 0, 2'b10, OWN,   5'd4,  16'h0,    "R2 readback");
        frame(32, 1, 2'b00, OWN,   5'd0,  16'h0005, "R6 address load");
        frame(32, 1, 2'b01, OWN,   5'd0,  16'hBEEF, "R6 ext write");
        frame(32, 0, 2'b10, OWN,   5'd5,  16'h0,    "R6 readback");
        frame(32, 0, 2'b01, OWN,   5'd6,  16'h6666, "R7 setup");
        frame(32, 1, 2'b11, OWN,   5'd0,  16'h0,    "R7 ext read");
        frame(32, 1, 2'b11, OWN,   5'd0,  16'h0,    "R7 ext read again");
        frame(32, 1, 2'b10, OWN,   5'd0,  16'h0,    "R7 read increment");
        frame(32, 1, 2'b11, OWN,   5'd0,  16'h0,    "R7 after increment");
        frame(32, 1, 2'b00, 5'd9,  5'd0,  16'h0002, "R5 foreign address load");
        frame(32, 1, 2'b11, OWN,   5'd0,  16'h0,    "R5 address kept");
        frame(32, 1, 2'b00, OWN,   5'd0,  16'h0010, "R8 address out of range");
        frame(32, 1, 2'b01, OWN,   5'd0,  16'h7777, "R8 ext write dropped");
        frame(32, 1, 2'b11, OWN,   5'd0,  16'h0,    "R8 ext read zero");
        frame(32, 0, 2'b01, OWN,   5'd20, 16'h4242, "R8 legacy write dropped");
        frame(32, 0, 2'b10, OWN,   5'd20, 16'h0,    "R8 legacy read zero");
        frame(32, 0, 2'b10, OWN,   5'd4,  16'h0,    "R8 no alias");
        frame(32, 0, 2'b10, OWN,   5'd0,  16'h0,    "R8 reg0 untouched");
        frame(32, 0, 2'b11, OWN,   5'd2,  16'h0,    "R9 op 11");
        frame(32, 0, 2'b00, OWN,   5'd2,  16'hFFFF, "R9 op 00");
        frame(32, 0, 2'b10, OWN,   5'd2,  16'h0,    "R9 readback");
        frame(40, 0, 2'b10, OWN,   5'd6,  16'h0,    "R2 long preamble");

        summary();
        $finish;
    end

endmodule